// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block is a synchronous reset sequencer for a processor subsystem. It merges three reset sources into one reset line. The first is a digital supply-good flag that an external comparator produces. The second is a manual push-button request, which is debounced. The third is a watchdog that expects steady activity on a monitored line. Whichever source fires, the reset stays asserted until every source has been quiet for a full hold-off period. Only then does it release.

All timing runs from a one-microsecond tick, which a prescaler derives from the clock. Every period is a parameter counted in ticks: the hold-off, the manual qualification time, the manual assertion delay and the watchdog timeout. The three inputs pass through two-flop synchronizers before any logic uses them. A build parameter sets the polarity of the reset output. A two-bit status output records which source caused the most recent assertion of reset.

Top module: `reset_supervisor`

## Requirements
- R1: While the synchronized `supply_ok` is low, reset is asserted. It asserts no more than 3 clock cycles after `supply_ok` falls.
- R2: Reset releases only after `supply_ok` has stayed high for `RST_HOLD_US` consecutive ticks. A low pulse inside that window restarts the count from zero.
- R3: A low pulse on `mr_n` that lasts `MR_QUAL_US` ticks or fewer has no effect on the reset output.
- R4: Once `mr_n` has been low for more than `MR_QUAL_US` ticks, the request qualifies. Reset then asserts after a further `MR_DELAY_US` ticks, even if `mr_n` has risen in the meantime.
- R5: Reset stays asserted for as long as `mr_n` is held low. It releases `RST_HOLD_US` ticks after `mr_n` returns high.
- R6: Each transition on `wdi`, rising or falling, restarts the watchdog count.
- R7: If `wdi` makes no transition for `WD_TIMEOUT_US` ticks, reset asserts. It then releases after the normal `RST_HOLD_US` hold-off.
- R8: The watchdog count is held at zero while reset is asserted. It starts counting from zero on the cycle after reset releases.
- R9: `rst_cause` is loaded only on the cycle reset newly asserts, and holds until the next assertion. The codes are 2'b00 for power-on clear, 2'b01 for supply, 2'b10 for manual and 2'b11 for watchdog. When several sources fire on the same cycle, supply wins over manual, and manual wins over watchdog.
- R10: With `ACTIVE_LOW`=1, `rst_out` is 0 when reset is asserted. With `ACTIVE_LOW`=0, the same state drives `rst_out` to 1.
- R11: While `arst_n` is low, reset is asserted, `rst_cause` reads 2'b00 and the hold-off count is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Power-on asynchronous clear, active low |
| supply_ok | input | 1 | Supply-good flag from the external comparator, asynchronous |
| mr_n | input | 1 | Manual reset request, active low, asynchronous |
| wdi | input | 1 | Watchdog activity line, asynchronous |
| rst_out | output | 1 | Reset output, polarity set by `ACTIVE_LOW` |
| rst_cause | output | 2 | Source of the most recent reset assertion |

## Verification
The bench builds the block with `CLK_PER_US`=1, so every clock cycle is one tick and each period can be measured in whole cycles. It uses a hold-off of 16 ticks, a qualification time of 10, a delay of 6 and a watchdog timeout of 40. With these short values, glitch restarts, qualification near its boundary, reset held longer than the hold-off and consecutive watchdog bites all fit into a few thousand cycles. A second instance with `ACTIVE_LOW`=0 shares the same inputs, so the two polarities can be compared side by side.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

  typedef enum logic [1:0] {
    CAUSE_POR    = 2'b00,
    CAUSE_SUPPLY = 2'b01,
    CAUSE_MANUAL = 2'b10,
    CAUSE_WDOG   = 2'b11
  } cause_e;

  typedef enum logic [1:0] {
    MRS_IDLE,
    MRS_QUAL,
    MRS_WAIT,
    MRS_HOLD
  } mr_state_e;

  // True on the last tick of a period of 'period' ticks, counting from zero.
  function automatic logic at_last(input int unsigned cnt, input int unsigned period);
    return cnt == period - 1;
  endfunction

  // Fixed priority: supply first, then manual, then watchdog.
  function automatic cause_e pick_cause(input logic sup_low, input logic mr, input logic bite);
    if (sup_low)   return CAUSE_SUPPLY;
    else if (mr)   return CAUSE_MANUAL;
    else if (bite) return CAUSE_WDOG;
    else           return CAUSE_POR;
  endfunction

endpackage

// File: rtl/rstsup_tick.sv
module rstsup_tick #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic arst_n,
  output logic tick
);
  localparam int W = $clog2(CLK_PER_US + 1);
  localparam logic [W-1:0] LAST = W'(CLK_PER_US - 1);

  logic [W-1:0] div_cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)              div_cnt <= '0;
    else if (div_cnt == LAST) div_cnt <= '0;
    else                      div_cnt <= div_cnt + 1'b1;
  end

  assign tick = (div_cnt == LAST);
endmodule

// File: rtl/rstsup_sync.sv
module rstsup_sync #(
  parameter int           N    = 3,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic meta, stable;
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        meta   <= INIT[i];
        stable <= INIT[i];
      end else begin
        meta   <= d[i];
        stable <= meta;
      end
    end
    assign q[i] = stable;
  end
endmodule

// File: rtl/rstsup_mr_qual.sv
module rstsup_mr_qual
  import rstsup_pkg::*;
#(
  parameter int MR_QUAL_US  = 25,
  parameter int MR_DELAY_US = 12
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick,
  input  logic mr_low,
  output logic mr_req
);
  localparam int MAXV = (MR_QUAL_US > MR_DELAY_US) ? MR_QUAL_US : MR_DELAY_US;
  localparam int W    = $clog2(MAXV + 2);

  mr_state_e    state;
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state <= MRS_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        MRS_IDLE: begin
          cnt <= '0;
          if (mr_low) state <= MRS_QUAL;
        end
        MRS_QUAL: begin
          if (!mr_low) begin
            state <= MRS_IDLE;
            cnt   <= '0;
          end else if (tick) begin
            // qualifies on the tick that makes the low time exceed MR_QUAL_US
            if (at_last(32'(cnt), MR_QUAL_US + 1)) begin
              state <= MRS_WAIT;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        MRS_WAIT: begin
          if (tick) begin
            if (at_last(32'(cnt), MR_DELAY_US)) begin
              state <= MRS_HOLD;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        MRS_HOLD: begin
          if (!mr_low) state <= MRS_IDLE;
        end
        default: state <= MRS_IDLE;
      endcase
    end
  end

  assign mr_req = (state == MRS_HOLD);
endmodule

// File: rtl/rstsup_wdog.sv
module rstsup_wdog
  import rstsup_pkg::*;
#(
  parameter int WD_TIMEOUT_US = 6200
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick,
  input  logic hold,
  input  logic wdi_s,
  output logic bite,
  output logic idle
);
  localparam int W = $clog2(WD_TIMEOUT_US + 1);

  logic [W-1:0] cnt;
  logic         wdi_prev;
  logic         wdi_edge;

  assign wdi_edge = wdi_s ^ wdi_prev;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      wdi_prev <= 1'b0;
      cnt      <= '0;
      bite     <= 1'b0;
    end else begin
      wdi_prev <= wdi_s;
      bite     <= 1'b0;
      if (hold || wdi_edge) begin
        cnt <= '0;
      end else if (tick) begin
        if (at_last(32'(cnt), WD_TIMEOUT_US)) begin
          cnt  <= '0;
          bite <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign idle = (cnt == '0);
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor
  import rstsup_pkg::*;
#(
  parameter int CLK_PER_US    = 50,
  parameter int RST_HOLD_US   = 200000,
  parameter int MR_QUAL_US    = 25,
  parameter int MR_DELAY_US   = 12,
  parameter int WD_TIMEOUT_US = 6200,
  parameter bit ACTIVE_LOW    = 1'b1
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       supply_ok,
  input  logic       mr_n,
  input  logic       wdi,
  output logic       rst_out,
  output logic [1:0] rst_cause
);
  localparam int HW = $clog2(RST_HOLD_US + 1);

  logic          tick;
  logic [2:0]    sync_q;
  logic          sup_ok_s, mr_low, wdi_s;
  logic          mr_req, wd_bite, wd_idle;
  logic          src_active;
  logic          rst_q;
  logic [HW-1:0] hold_cnt;
  cause_e        cause_q;

  rstsup_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .arst_n(arst_n), .tick(tick)
  );

  // bit order {wdi, mr_n, supply_ok}; mr_n idles high
  rstsup_sync #(.N(3), .INIT(3'b010)) u_sync (
    .clk(clk), .arst_n(arst_n), .d({wdi, mr_n, supply_ok}), .q(sync_q)
  );

  assign sup_ok_s = sync_q[0];
  assign mr_low   = ~sync_q[1];
  assign wdi_s    = sync_q[2];

  rstsup_mr_qual #(.MR_QUAL_US(MR_QUAL_US), .MR_DELAY_US(MR_DELAY_US)) u_mr (
    .clk(clk), .arst_n(arst_n), .tick(tick), .mr_low(mr_low), .mr_req(mr_req)
  );

  rstsup_wdog #(.WD_TIMEOUT_US(WD_TIMEOUT_US)) u_wd (
    .clk(clk), .arst_n(arst_n), .tick(tick), .hold(rst_q),
    .wdi_s(wdi_s), .bite(wd_bite), .idle(wd_idle)
  );

  assign src_active = ~sup_ok_s | mr_req | wd_bite;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_q    <= 1'b1;
      hold_cnt <= '0;
      cause_q  <= CAUSE_POR;
    end else if (src_active) begin
      rst_q    <= 1'b1;
      hold_cnt <= '0;
      if (!rst_q) cause_q <= pick_cause(~sup_ok_s, mr_req, wd_bite);
    end else if (rst_q && tick) begin
      if (at_last(32'(hold_cnt), RST_HOLD_US)) begin
        rst_q    <= 1'b0;
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end

  assign rst_cause = cause_q;

  if (ACTIVE_LOW) begin : g_act_low
    assign rst_out = ~rst_q;
  end else begin : g_act_high
    assign rst_out = rst_q;
  end
endmodule

// File: rtl/rstsup_checker.sv
module rstsup_checker (
  input logic       clk,
  input logic       arst_n,
  input logic       sup_ok_s,
  input logic       mr_req,
  input logic       wd_bite,
  input logic       src_active,
  input logic       rst_q,
  input logic       wd_idle,
  input logic [1:0] cause
);
  assert_supply_low_R1: assert property (@(posedge clk) disable iff (!arst_n)
    !sup_ok_s |=> rst_q);

  assert_quiet_release_R2: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rst_q) |-> !$past(src_active));

  assert_manual_asserts_R4: assert property (@(posedge clk) disable iff (!arst_n)
    mr_req |=> rst_q);

  assert_bite_asserts_R7: assert property (@(posedge clk) disable iff (!arst_n)
    wd_bite |=> rst_q);

  assert_wd_held_R8: assert property (@(posedge clk) disable iff (!arst_n)
    rst_q |=> wd_idle);

  assert_cause_stable_R9: assert property (@(posedge clk) disable iff (!arst_n)
    (rst_q && $past(rst_q)) |-> $stable(cause));
endmodule

bind reset_supervisor rstsup_checker u_chk (
  .clk(clk), .arst_n(arst_n), .sup_ok_s(sup_ok_s), .mr_req(mr_req),
  .wd_bite(wd_bite), .src_active(src_active), .rst_q(rst_q),
  .wd_idle(wd_idle), .cause(rst_cause)
);

// File: tb/reset_supervisor_tb.sv
module reset_supervisor_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HOLD = 16, QUAL = 10, DLY = 6, WDT = 40;
  localparam int  TOL  = 3;
  localparam int  MR_ON_EXP = QUAL + DLY + 4;   // 2 sync + entry + qualify + delay + latch
  // manual vectors: {low length in cycles, expect reset}
  localparam logic [15:0] MR_VEC [6] = '{16'h0300, 16'h0600, 16'h0800,
                                         16'h0E01, 16'h1401, 16'h2801};

  logic clk = 1'b0, arst_n = 1'b0, supply_ok = 1'b0, mr_n = 1'b1, wdi = 1'b0;
  logic rst_lo, rst_hi;
  logic [1:0] cause, cause_hi;
  logic pet_en = 1'b0;
  int   pet_gap = 8, pcnt = 0;
  int   n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_supervisor #(.CLK_PER_US(1), .RST_HOLD_US(HOLD), .MR_QUAL_US(QUAL),
    .MR_DELAY_US(DLY), .WD_TIMEOUT_US(WDT), .ACTIVE_LOW(1'b1)) u_dut (
    .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .mr_n(mr_n), .wdi(wdi),
    .rst_out(rst_lo), .rst_cause(cause));

  reset_supervisor #(.CLK_PER_US(1), .RST_HOLD_US(HOLD), .MR_QUAL_US(QUAL),
    .MR_DELAY_US(DLY), .WD_TIMEOUT_US(WDT), .ACTIVE_LOW(1'b0)) u_dut_hi (
    .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .mr_n(mr_n), .wdi(wdi),
    .rst_out(rst_hi), .rst_cause(cause_hi));

  function automatic logic rst_on();
    return rst_lo == 1'b0;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic near(input string req, input int act, input int exp);
    check((act >= exp - TOL) && (act <= exp + TOL), req, act, exp);
  endtask

  task automatic measure(input logic want_on, input int maxc, output int n);
    n = 0;
    while (rst_on() != want_on && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // watchdog keep-alive driver
  initial forever begin
    @(negedge clk);
    if (pet_en) begin
      pcnt++;
      if (pcnt >= pet_gap) begin
        wdi  = ~wdi;
        pcnt = 0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL run watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(rst_on(), "R11 reset asserted in clear", int'(rst_lo), 0);
    check(cause == 2'b00, "R11 cause in clear", int'(cause), 0);
    check(rst_hi == 1'b1, "R10 active-high polarity", int'(rst_hi), 1);
    arst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(rst_on(), "R1 held while supply low", int'(rst_lo), 0);

    // R2: release after full hold
    supply_ok = 1'b1;
    pet_en = 1'b1;
    measure(1'b0, 100, n);
    near("R2 release after supply rise", n, HOLD + 2);
    check(cause == 2'b00, "R9 cause stays power-on", int'(cause), 0);
    check(rst_hi == ~rst_lo, "R10 polarities opposite", int'(rst_hi), int'(~rst_lo));

    // R1: supply drop, then R2 glitch restart
    supply_ok = 1'b0;
    measure(1'b1, 20, n);
    near("R1 assert latency", n, 3);
    check(cause == 2'b01, "R9 cause supply", int'(cause), 1);
    repeat (10) @(negedge clk);
    supply_ok = 1'b1;
    repeat (8) @(negedge clk);
    supply_ok = 1'b0;
    repeat (3) @(negedge clk);
    check(rst_on(), "R2 still held during glitch", int'(rst_lo), 0);
    supply_ok = 1'b1;
    measure(1'b0, 100, n);
    near("R2 restart after glitch", n, HOLD + 2);

    // R3 R4 R5: manual vector table
    for (int v = 0; v < 6; v++) begin
      int len, on_at, off_at, exp_off;
      logic exp_on;
      len    = int'(MR_VEC[v][15:8]);
      exp_on = MR_VEC[v][0];
      on_at  = -1;
      off_at = -1;
      mr_n   = 1'b0;
      for (int c = 0; c < 120; c++) begin
        @(negedge clk);
        if (c == len - 1) mr_n = 1'b1;
        if (on_at < 0 && rst_on()) on_at = c;
        if (on_at >= 0 && off_at < 0 && !rst_on()) off_at = c;
        if (len == 40 && c == len - 2) check(rst_on(), "R5 held while mr_n low", int'(rst_lo), 0);
      end
      if (!exp_on) begin
        check(on_at < 0, "R3 short manual pulse ignored", on_at, -1);
      end else begin
        exp_off = ((len + 3 > MR_ON_EXP + 1) ? len + 3 : MR_ON_EXP + 1) + HOLD;
        near("R4 manual assert latency", on_at, MR_ON_EXP);
        near("R5 manual release", off_at, exp_off);
        check(cause == 2'b10, "R9 cause manual", int'(cause), 2);
      end
    end

    // R6: toggling every 30 cycles, each edge counts
    pet_gap = 30;
    n = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (rst_on()) n++;
    end
    check(n == 0, "R6 both wdi edges restart count", n, 0);

    // R7: stop activity
    pet_en = 1'b0;
    repeat (2) @(negedge clk);
    wdi = ~wdi;
    measure(1'b1, 200, n);
    near("R7 watchdog timeout", n, WDT + 4);
    check(cause == 2'b11, "R9 cause watchdog", int'(cause), 3);
    measure(1'b0, 100, n);
    near("R7 hold after watchdog", n, HOLD);
    measure(1'b1, 200, n);
    near("R8 count starts at release", n, WDT + 1);

    // R8: long reset without activity, count must restart from zero
    measure(1'b0, 100, n);
    supply_ok = 1'b0;
    repeat (200) @(negedge clk);
    supply_ok = 1'b1;
    measure(1'b0, 100, n);
    near("R8 release after long supply low", n, HOLD + 2);
    measure(1'b1, 200, n);
    near("R8 watchdog held during reset", n, WDT + 1);
    check(cause == 2'b11, "R9 cause watchdog again", int'(cause), 3);

    finish_run();
  end
endmodule